// File: doc/BRIEF.md
# Load/Store Exclusive Reservation Monitor

This block tracks one load-linked / store-conditional reservation for a single core doing 32-bit aligned accesses. A load-exclusive reads a word from memory and arms a reservation on the granule that holds the address. A later store-exclusive to the same granule writes only while that reservation is still alive. It then returns 1 on the response data lane, which is where the core writes back into the register that held the store data. A store that loses returns 0 and never reaches memory.

The reservation can be cancelled by an explicit clear command, by a pulse that marks an exception or interrupt return, and by a snooped write from another master that hits the reserved granule. Each memory category, decoded from the address, has a 2-bit handling policy held in a control register. The policy decides whether a winning store goes out as an internal read-conditional-write, an internal bus exclusive or an external exclusive transaction, or is refused with a load/store error. Only privileged code, or code in debug mode, can read or write the control register. Memory is a plain same-cycle request/response port. Every request gets a registered response one cycle after it is issued.

Top module: `resv_monitor`

## Requirements
- R1: A load-exclusive (`req_op`=1) with `req_addr[1:0]`=0 drives one memory read at that address. The next cycle it returns `mem_rdata` on `rsp_data` and leaves a reservation on the granule `req_addr & ~(GRAN_BYTES-1)`.
- R2: A store-exclusive (`req_op`=2) finds no live reservation on its granule. It makes no memory write and returns `rsp_data`=0 with no error flag.
- R3: A store-exclusive that holds the reservation, under a policy other than 3, writes `req_wdata` with `mem_kind` equal to the policy. It returns `rsp_data`=1 and clears the reservation, so a repeated store-exclusive returns 0.
- R4: A clear command (`req_op`=3) cancels the reservation. So does an `exc_return` pulse.
- R5: A snoop (`snoop_valid`) to the reserved granule cancels the reservation. A snoop to any other granule leaves it intact.
- R6: The category is `req_addr[30:28]` saturated to 4. The policy is control bits [2c+1:2c], coded 0 internal read-conditional-write, 1 internal bus exclusive, 2 external exclusive, 3 error. Policy 3 writes nothing, returns `rsp_lserr`=1 with `rsp_data`=0, and clears the reservation.
- R7: A control read (`req_op`=4) returns the 10-bit policy field in bits [9:0], the constant `CSR_CONST` (default 14'h1C3) in bits [23:10] and zero above. A control write (`req_op`=5) loads `req_wdata[9:0]`.
- R8: A control read or write issued with `priv_user`=1 and `debug_mode`=0 raises `rsp_priv_trap`, returns 0 and leaves the policy unchanged. Exclusive operations are allowed in user mode.
- R9: An exclusive access with `req_addr[1:0]`≠0 raises `rsp_align_trap`. It touches no memory and leaves the reservation as it was.
- R10: A load-exclusive to a new granule replaces the earlier reservation, so a store-exclusive to the old granule fails.
- R11: A store-exclusive issued in the cycle right after a control write uses the newly written policy.
- R12: When a cancel event and a store-exclusive fall in the same cycle, the store fails. When a cancel event and a load-exclusive fall in the same cycle, the new reservation stands.
- R13: After reset there is no reservation, `rsp_valid` is 0 and the policy field equals `POLICY_RESET` (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 0 idle, 1 load-excl, 2 store-excl, 3 clear, 4 control read, 5 control write |
| req_addr | input | ADDR_W | Byte address of the exclusive access |
| req_wdata | input | 32 | Store data or control write data |
| priv_user | input | 1 | Core is in a non-zero (user) ring |
| debug_mode | input | 1 | Core is under debug control |
| exc_return | input | 1 | Exception or interrupt return pulse |
| snoop_valid | input | 1 | Foreign write observed |
| snoop_addr | input | ADDR_W | Address of the foreign write |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_kind | output | 2 | Store handling kind (policy code) |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, same cycle |
| rsp_valid | output | 1 | Response for last cycle's request |
| rsp_data | output | 32 | Load data, store status or control value |
| rsp_lserr | output | 1 | Load/store error from policy 3 |
| rsp_align_trap | output | 1 | Misaligned exclusive |
| rsp_priv_trap | output | 1 | Control access denied |

## Verification
Two functions can land in the same cycle: an operation on the request port and a cancel event, which is either an exception-return pulse or a snoop hitting the reserved granule. The bench drives them together on purpose. It does so in directed steps, a store-exclusive with a matching snoop and a load-exclusive with `exc_return`, and again at random over a small address pool so that snoops often hit. A store under a same-cycle cancel must return status 0 and leave memory untouched. A load under a same-cycle cancel must leave a reservation that a following store-exclusive wins.

// File: rtl/resv_pkg.sv
package resv_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_LDEX  = 3'd1,
        OP_STEX  = 3'd2,
        OP_CLR   = 3'd3,
        OP_CSRRD = 3'd4,
        OP_CSRWR = 3'd5
    } resv_op_e;

    typedef enum logic [1:0] {
        POL_RCW   = 2'd0,
        POL_INTEX = 2'd1,
        POL_EXTEX = 2'd2,
        POL_ERROR = 2'd3
    } resv_pol_e;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
        logic              lserr;
        logic              align;
        logic              priv;
    } resv_rsp_t;
endpackage

// File: rtl/resv_cat_decode.sv
module resv_cat_decode #(
    parameter int ADDR_W  = 32,
    parameter int NUM_CAT = 5,
    parameter int CAT_LSB = 28,
    localparam int FIELD_W = 2 * NUM_CAT,
    localparam int CAT_W   = (NUM_CAT > 1) ? $clog2(NUM_CAT) : 1
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FIELD_W-1:0] field,
    output logic [1:0]         pol
);
    logic [1:0]       pol_arr [NUM_CAT];
    logic [CAT_W-1:0] raw_idx;
    logic [CAT_W-1:0] sel_idx;

    // one policy slot per memory category
    for (genvar c = 0; c < NUM_CAT; c++) begin : g_slot
        assign pol_arr[c] = field[2*c +: 2];
    end

    assign raw_idx = addr[CAT_LSB +: CAT_W];

    always_comb begin
        if (int'(raw_idx) >= NUM_CAT) sel_idx = CAT_W'(NUM_CAT - 1);
        else                          sel_idx = raw_idx;
        pol = pol_arr[sel_idx];
    end
endmodule

// File: rtl/resv_policy_csr.sv
module resv_policy_csr #(
    parameter int FIELD_W = 10,
    parameter logic [FIELD_W-1:0] POLICY_RESET = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_field,
    output logic [FIELD_W-1:0] field
);
    logic [FIELD_W-1:0] field_d, field_q;

    always_comb begin
        field_d = field_q;
        if (wr_en) field_d = wr_field;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) field_q <= POLICY_RESET;
        else        field_q <= field_d;
    end

    assign field = field_q;
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int GRAN_BYTES = 4,
    parameter int NUM_CAT    = 5,
    parameter int CAT_LSB    = 28,
    parameter logic [13:0] CSR_CONST = 14'h1C3,
    parameter logic [2*NUM_CAT-1:0] POLICY_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              priv_user,
    input  logic              debug_mode,
    input  logic              exc_return,
    input  logic              snoop_valid,
    input  logic [ADDR_W-1:0] snoop_addr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_kind,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data,
    output logic              rsp_lserr,
    output logic              rsp_align_trap,
    output logic              rsp_priv_trap
);
    localparam int FIELD_W = 2 * NUM_CAT;
    localparam int PAD_W   = WORD_W - 14 - FIELD_W;
    localparam logic [ADDR_W-1:0] GRAN_MASK = ~(ADDR_W'(GRAN_BYTES - 1));

    typedef struct packed {
        logic              resv_valid;
        logic [ADDR_W-1:0] resv_gran;
        resv_rsp_t         rsp;
    } mon_state_t;

    mon_state_t st_d, st_q;

    logic [FIELD_W-1:0] policy_field;
    logic [1:0]         req_pol;
    logic               csr_we;
    logic               resv_valid_q;
    logic [ADDR_W-1:0]  resv_gran_q;

    resv_cat_decode #(
        .ADDR_W (ADDR_W),
        .NUM_CAT(NUM_CAT),
        .CAT_LSB(CAT_LSB)
    ) u_cat (
        .addr (req_addr),
        .field(policy_field),
        .pol  (req_pol)
    );

    resv_policy_csr #(
        .FIELD_W     (FIELD_W),
        .POLICY_RESET(POLICY_RESET)
    ) u_csr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (csr_we),
        .wr_field(req_wdata[FIELD_W-1:0]),
        .field   (policy_field)
    );

    assign resv_valid_q = st_q.resv_valid;
    assign resv_gran_q  = st_q.resv_gran;

    always_comb begin
        logic       kill;
        logic       misaligned;
        logic       hit;
        logic       denied;
        resv_op_e   op;

        op         = resv_op_e'(req_valid ? req_op : 3'd0);
        // cancel events judged against the reservation held before this cycle
        kill       = exc_return ||
                     (snoop_valid && st_q.resv_valid &&
                      ((snoop_addr & GRAN_MASK) == st_q.resv_gran));
        misaligned = (req_addr[1:0] != 2'b00);
        hit        = st_q.resv_valid && !kill &&
                     ((req_addr & GRAN_MASK) == st_q.resv_gran);
        denied     = priv_user && !debug_mode;

        st_d            = st_q;
        st_d.resv_valid = st_q.resv_valid && !kill;
        st_d.rsp        = '0;
        st_d.rsp.valid  = (op != OP_IDLE);

        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_kind  = 2'b00;
        mem_addr  = req_addr;
        mem_wdata = req_wdata;
        csr_we    = 1'b0;

        unique case (op)
            OP_LDEX: begin
                if (misaligned) begin
                    st_d.rsp.align = 1'b1;
                end else begin
                    mem_req         = 1'b1;
                    st_d.rsp.data   = mem_rdata;
                    st_d.resv_valid = 1'b1;
                    st_d.resv_gran  = req_addr & GRAN_MASK;
                end
            end
            OP_STEX: begin
                if (misaligned) begin
                    st_d.rsp.align = 1'b1;
                end else if (hit) begin
                    st_d.resv_valid = 1'b0;
                    if (req_pol == POL_ERROR) begin
                        st_d.rsp.lserr = 1'b1;
                    end else begin
                        mem_req       = 1'b1;
                        mem_we        = 1'b1;
                        mem_kind      = req_pol;
                        st_d.rsp.data = 32'd1;
                    end
                end
            end
            OP_CLR: begin
                st_d.resv_valid = 1'b0;
            end
            OP_CSRRD: begin
                if (denied) st_d.rsp.priv = 1'b1;
                else        st_d.rsp.data = {{PAD_W{1'b0}}, CSR_CONST, policy_field};
            end
            OP_CSRWR: begin
                if (denied) st_d.rsp.priv = 1'b1;
                else        csr_we = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid      = st_q.rsp.valid;
    assign rsp_data       = st_q.rsp.data;
    assign rsp_lserr      = st_q.rsp.lserr;
    assign rsp_align_trap = st_q.rsp.align;
    assign rsp_priv_trap  = st_q.rsp.priv;
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
    parameter int ADDR_W     = 32,
    parameter int GRAN_BYTES = 4,
    parameter int FIELD_W    = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              priv_user,
    input logic              debug_mode,
    input logic              exc_return,
    input logic              mem_req,
    input logic              mem_we,
    input logic [1:0]        mem_kind,
    input logic              rsp_data_is_one,
    input logic              resv_valid_q,
    input logic [ADDR_W-1:0] resv_gran_q,
    input logic [FIELD_W-1:0] policy_field
);
    localparam logic [ADDR_W-1:0] GMASK = ~(ADDR_W'(GRAN_BYTES - 1));

    // R2
    store_needs_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (resv_valid_q && ((req_addr & GMASK) == resv_gran_q)));

    // R3
    win_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (!resv_valid_q && rsp_data_is_one));

    // R6
    no_error_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_kind != 2'b11));

    // R9
    misaligned_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == 3'd1 || req_op == 3'd2) && req_addr[1:0] != 2'b00)
        |-> !mem_req);

    // R8
    user_csr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 3'd5 && priv_user && !debug_mode) |=> $stable(policy_field));

    // R4
    exc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_return && !(req_valid && req_op == 3'd1)) |=> !resv_valid_q);
endmodule

bind resv_monitor resv_monitor_chk #(
    .ADDR_W    (ADDR_W),
    .GRAN_BYTES(GRAN_BYTES),
    .FIELD_W   (2 * NUM_CAT)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_op         (req_op),
    .req_addr       (req_addr),
    .priv_user      (priv_user),
    .debug_mode     (debug_mode),
    .exc_return     (exc_return),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_kind       (mem_kind),
    .rsp_data_is_one(rsp_data == 32'd1),
    .resv_valid_q   (resv_valid_q),
    .resv_gran_q    (resv_gran_q),
    .policy_field   (policy_field)
);

// File: tb/resv_monitor_tb_top.sv
module resv_monitor_tb_top;
    localparam logic [13:0] CONST_BITS = 14'h1C3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = 3'd0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        priv_user = 1'b0;
    logic        debug_mode = 1'b0;
    logic        exc_return = 1'b0;
    logic        snoop_valid = 1'b0;
    logic [31:0] snoop_addr = '0;
    logic        mem_req, mem_we;
    logic [1:0]  mem_kind;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        rsp_valid, rsp_lserr, rsp_align_trap, rsp_priv_trap;
    logic [31:0] rsp_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model state
    bit          m_v = 1'b0;
    logic [31:0] m_g = '0;
    logic [9:0]  m_f = '0;

    always #2.5 clk = ~clk;

    assign mem_rdata = {mem_addr[15:0], ~mem_addr[15:0]};

    resv_monitor dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .priv_user(priv_user),
        .debug_mode(debug_mode), .exc_return(exc_return), .snoop_valid(snoop_valid),
        .snoop_addr(snoop_addr), .mem_req(mem_req), .mem_we(mem_we), .mem_kind(mem_kind),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_lserr(rsp_lserr),
        .rsp_align_trap(rsp_align_trap), .rsp_priv_trap(rsp_priv_trap)
    );

    function automatic logic [31:0] gran(input logic [31:0] a);
        return a & ~32'd3;
    endfunction

    function automatic logic [1:0] pol_of(input logic [31:0] a, input logic [9:0] f);
        int c;
        c = int'(a[30:28]);
        if (c > 4) c = 4;
        return f[2*c +: 2];
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] op, input logic [31:0] addr, input logic [31:0] wd,
                        input bit user, input bit dbg, input bit exc, input bit snv,
                        input logic [31:0] sna, input string tag);
        bit kill, mis, hit, den;
        logic [31:0] e_data;
        bit e_err, e_al, e_pr, e_we, e_val;
        logic [1:0] e_kind, pol;
        bit nv;
        logic [31:0] ng;
        logic [9:0] nf;

        kill = exc || (snv && m_v && gran(sna) == m_g);
        mis  = addr[1:0] != 2'b00;
        hit  = m_v && !kill && gran(addr) == m_g;
        den  = user && !dbg;
        pol  = pol_of(addr, m_f);
        e_data = '0; e_err = 0; e_al = 0; e_pr = 0; e_we = 0; e_kind = 2'd0;
        e_val = (op != 3'd0);
        nv = m_v && !kill; ng = m_g; nf = m_f;
        case (op)
            3'd1: if (mis) e_al = 1;
                  else begin e_data = {addr[15:0], ~addr[15:0]}; nv = 1; ng = gran(addr); end
            3'd2: if (mis) e_al = 1;
                  else if (hit) begin
                      nv = 0;
                      if (pol == 2'd3) e_err = 1;
                      else begin e_we = 1; e_kind = pol; e_data = 32'd1; end
                  end
            3'd3: nv = 0;
            3'd4: if (den) e_pr = 1; else e_data = {8'h00, CONST_BITS, m_f};
            3'd5: if (den) e_pr = 1; else nf = wd[9:0];
            default: ;
        endcase

        req_valid = (op != 3'd0); req_op = op; req_addr = addr; req_wdata = wd;
        priv_user = user; debug_mode = dbg; exc_return = exc;
        snoop_valid = snv; snoop_addr = sna;
        #1;
        check({tag, " mem write"}, {61'd0, (mem_req && mem_we), (mem_we ? mem_kind : 2'd0)},
              {61'd0, e_we, e_kind});
        if (e_we) check({tag, " mem wdata"}, {32'd0, mem_wdata}, {32'd0, wd});
        @(negedge clk);
        check(tag, {rsp_valid, rsp_lserr, rsp_align_trap, rsp_priv_trap, 28'd0, rsp_data},
              {e_val, e_err, e_al, e_pr, 28'd0, e_data});
        m_v = nv; m_g = ng; m_f = nf;
    endtask

    function automatic logic [31:0] rnd_addr();
        logic [31:0] r;
        r = $urandom;
        return {1'b0, r[2:0], 20'h0, 2'b0, r[5:3], ((r[9:6] == 0) ? r[11:10] : 2'b00)};
    endfunction

    initial begin
        logic [31:0] a, b, c7;
        void'($urandom(32'h1234_5678));
        a  = 32'h0000_0040;
        b  = 32'h0000_0080;
        c7 = 32'h7000_0010;
        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        step(3'd4, 0, 0, 0, 0, 0, 0, 0, "R13 R7 policy reset readback");
        // R1 R3 basic win then repeat loses
        step(3'd1, a, 0, 1, 0, 0, 0, 0, "R1 load-exclusive user mode");
        step(3'd2, a, 32'hCAFE_0001, 1, 0, 0, 0, 0, "R3 winning store");
        step(3'd2, a, 32'hCAFE_0002, 0, 0, 0, 0, 0, "R3 R2 repeat store loses");
        // R4
        step(3'd1, a, 0, 0, 0, 0, 0, 0, "R1 arm");
        step(3'd3, 0, 0, 0, 0, 0, 0, 0, "R4 clear command");
        step(3'd2, a, 32'h1, 0, 0, 0, 0, 0, "R4 store after clear");
        step(3'd1, a, 0, 0, 0, 0, 0, 0, "R1 arm");
        step(3'd0, 0, 0, 0, 0, 1, 0, 0, "R4 exception return");
        step(3'd2, a, 32'h2, 0, 0, 0, 0, 0, "R4 store after exc return");
        // R5
        step(3'd1, a, 0, 0, 0, 0, 0, 0, "R1 arm");
        step(3'd0, 0, 0, 0, 0, 0, 1, b, "R5 snoop other granule");
        step(3'd2, a, 32'h3, 0, 0, 0, 0, 0, "R5 store survives foreign snoop");
        step(3'd1, a, 0, 0, 0, 0, 0, 0, "R1 arm");
        step(3'd0, 0, 0, 0, 0, 0, 1, a, "R5 snoop same granule");
        step(3'd2, a, 32'h4, 0, 0, 0, 0, 0, "R5 store after hit snoop");
        // R8
        step(3'd5, 0, 32'h3FF, 1, 0, 0, 0, 0, "R8 user write denied");
        step(3'd4, 0, 0, 1, 0, 0, 0, 0, "R8 user read denied");
        step(3'd4, 0, 0, 0, 0, 0, 0, 0, "R8 policy unchanged");
        step(3'd5, 0, 32'hFFFF_FC00 | 32'h20C, 1, 1, 0, 0, 0, "R8 R7 debug write allowed");
        step(3'd4, 0, 0, 0, 0, 0, 0, 0, "R7 readback");
        // R6: cat1 -> 3 error, cat4 (and 7) -> 2 external, cat0 -> 0
        step(3'd1, 32'h1000_0020, 0, 0, 0, 0, 0, 0, "R1 arm cat1");
        step(3'd2, 32'h1000_0020, 32'h5, 0, 0, 0, 0, 0, "R6 error policy");
        step(3'd2, 32'h1000_0020, 32'h5, 0, 0, 0, 0, 0, "R6 error cleared reservation");
        step(3'd1, c7, 0, 0, 0, 0, 0, 0, "R1 arm cat7");
        step(3'd2, c7, 32'h6, 0, 0, 0, 0, 0, "R6 saturated category");
        // R9
        step(3'd1, a, 0, 0, 0, 0, 0, 0, "R1 arm");
        step(3'd1, b | 32'h2, 0, 0, 0, 0, 0, 0, "R9 misaligned load");
        step(3'd2, a | 32'h1, 32'h7, 0, 0, 0, 0, 0, "R9 misaligned store");
        step(3'd2, a, 32'h8, 0, 0, 0, 0, 0, "R9 reservation kept");
        // R10
        step(3'd1, a, 0, 0, 0, 0, 0, 0, "R1 arm first");
        step(3'd1, b, 0, 0, 0, 0, 0, 0, "R10 arm second");
        step(3'd2, a, 32'h9, 0, 0, 0, 0, 0, "R10 old granule loses");
        step(3'd2, b, 32'hA, 0, 0, 0, 0, 0, "R10 new granule wins");
        // R11
        step(3'd1, a, 0, 0, 0, 0, 0, 0, "R1 arm");
        step(3'd5, 0, 32'h001, 0, 0, 0, 0, 0, "R11 write policy");
        step(3'd2, a, 32'hB, 0, 0, 0, 0, 0, "R11 store uses new policy");
        // R12
        step(3'd1, a, 0, 0, 0, 0, 0, 0, "R1 arm");
        step(3'd2, a, 32'hC, 0, 0, 0, 1, a, "R12 store with same-cycle snoop");
        step(3'd1, a, 0, 0, 0, 1, 0, 0, "R12 load with same-cycle exc return");
        step(3'd2, a, 32'hD, 0, 0, 0, 0, 0, "R12 reservation stands");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            logic [2:0] op;
            r = $urandom;
            case (r[3:0])
                0, 1, 2, 3, 4:  op = 3'd1;
                5, 6, 7, 8, 9:  op = 3'd2;
                10:             op = 3'd3;
                11:             op = 3'd4;
                12:             op = 3'd5;
                default:        op = 3'd0;
            endcase
            step(op, rnd_addr(), $urandom, r[4], r[5] & r[6], (r[10:7] == 0),
                 r[11], rnd_addr() & ~32'd3, "R12 random mix");
        end
        step(3'd0, 0, 0, 0, 0, 0, 0, 0, "R13 idle");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule